// File: doc/BRIEF.md
# Packetized SPI Transfer Sequencer

This block runs one SPI master transfer as a series of equal-sized packets. Software sets a packet size and a packet count, each written as the real value minus one, and then issues a start command. The sequencer then walks through every byte of every packet. It drives the serial clock, MOSI and an active-low chip select. It takes transmit bytes from a show-ahead source and hands each received byte to a sink with a one-cycle strobe.

Within a packet, bytes either run back to back (non-idle mode) or are separated by a short gap with chip select held low. Between packets, chip select goes high for a short gap. After the last packet the transfer either finishes or, with pause enabled, holds chip select low and waits. A resume command then runs another transfer of the programmed size. Finish and pause are reported on a two-bit status and can each raise an interrupt. A command-level reset clears the sequencer, and a loopback mode feeds MOSI back into the receive path.

Top module: `spiseq_top`

## Requirements
- R1: After reset the outputs are idle: cs_n=1, sck=0, busy=0, status=2'b00, irq=0, byte_req=0 and rx_valid=0. Whenever busy is 0, cs_n is 1.
- R2: cmd_act, sampled high while idle, pulls cs_n low and loads the first byte on the same edge. byte_req is high for exactly the one cycle after each byte load, and tx_byte is captured on that load edge. cmd_act is ignored while busy or paused.
- R3: Each byte uses SPI mode 0, MSB first. sck starts low, each half period lasts SCK_HALF cycles, a byte takes 16*SCK_HALF cycles, and mosi moves to the next bit on each falling sck edge.
- R4: pkt_len_m1 (LEN_W bits) holds bytes per packet minus one, and pkt_loop_m1 (8 bits) holds packets minus one. A transfer moves (pkt_len_m1+1)*(pkt_loop_m1+1) bytes. Both values are latched at start and at resume.
- R5: With nonidle_en=1, the next byte of a packet loads on the same edge the previous byte ends. With nonidle_en=0, GAP_CYC cycles pass between bytes, with cs_n held low.
- R6: Between packets cs_n goes high for GAP_CYC cycles, then goes low as the next packet's first byte loads.
- R7: When the last byte of the last packet ends with pause_en=0, cs_n rises, busy falls and status becomes 2'b01. That status holds until the next cmd_act. irq goes high one cycle after status bit 0 is set, when finish_ie=1.
- R8: When the last byte ends with pause_en=1, cs_n stays low, busy stays high and status becomes 2'b10. irq goes high one cycle later when pause_ie=1. cmd_resume in that state clears status and runs a new transfer. cmd_resume is ignored in every other state.
- R9: While cmd_rst is high, the block returns to idle and holds there (R1 values), and all counters and status are cleared.
- R10: At the end of each byte, rx_valid pulses for one cycle and rx_byte holds the 8 bits sampled on the rising sck edges, MSB first. The sampled line is mosi when loop_en=1 and miso otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_act | input | 1 | Start command (one-cycle pulse) |
| cmd_resume | input | 1 | Resume a paused transfer (one-cycle pulse) |
| cmd_rst | input | 1 | Command-level clear, held while high |
| pause_en | input | 1 | Pause after the last packet instead of finishing |
| nonidle_en | input | 1 | Back-to-back bytes within a packet |
| loop_en | input | 1 | Receive path samples mosi instead of miso |
| finish_ie | input | 1 | Finish interrupt enable |
| pause_ie | input | 1 | Pause interrupt enable |
| pkt_len_m1 | input | LEN_W | Bytes per packet minus one |
| pkt_loop_m1 | input | LOOP_W | Packets per transfer minus one |
| tx_byte | input | 8 | Head byte of the transmit source |
| byte_req | output | 1 | Pop strobe toward the transmit source |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| busy | output | 1 | Transfer running or paused |
| status | output | 2 | Bit 0 finished, bit 1 paused (value 2'b10) |
| irq | output | 1 | Interrupt |

## Verification
A behavioural model predicts every registered output on every clock and is run through five patterns.

- A single back-to-back packet in loopback, with a repeated start in the middle, shows that bytes are contiguous and that a start while busy is ignored.
- A multi-packet run with idle gaps and miso held high separates the intra-packet gap from the chip-select gap between packets, and separates miso sampling from loopback.
- A paused run followed by a resume exercises the hold state, the 2'b10 status code and the two interrupt enables.
- A clear in the middle of a transfer, a one-byte transfer, a packet length using the upper field bits and a full 256-packet loop cover the remaining edges of the counters.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_BGAP,
    ST_PGAP,
    ST_HOLD
  } seq_state_t;

  typedef struct packed {
    logic paused;
    logic done;
  } seq_status_t;

endpackage

// File: rtl/spiseq_shift.sv
module spiseq_shift #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kill,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       loop_en,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_end,
  output logic       byte_req,
  output logic       rx_valid,
  output logic [7:0] rx_byte
);
  localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

  logic            active;
  logic [HC_W-1:0] hc;
  logic [3:0]      hi;
  logic [7:0]      tx_sh;
  logic [7:0]      rx_sh;
  logic            half_tick;
  logic            rx_bit;

  assign half_tick = active && (hc == HC_LAST);
  assign byte_end  = half_tick && (hi == 4'd15);
  assign mosi      = tx_sh[7];
  assign rx_bit    = loop_en ? tx_sh[7] : miso;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      active   <= 1'b0;
      hc       <= '0;
      hi       <= '0;
      sck      <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      byte_req <= 1'b0;
    end else begin
      byte_req <= 1'b0;
      rx_valid <= 1'b0;
      if (half_tick) begin
        hc <= '0;
        if (hi == 4'd15) begin
          active   <= 1'b0;
          sck      <= 1'b0;
          rx_valid <= 1'b1;
          rx_byte  <= rx_sh;
        end else begin
          hi  <= hi + 4'd1;
          sck <= ~sck;
          if (!hi[0]) rx_sh <= {rx_sh[6:0], rx_bit};
          else        tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end else if (active) begin
        hc <= hc + 1'b1;
      end
      if (load) begin
        active   <= 1'b1;
        hc       <= '0;
        hi       <= '0;
        sck      <= 1'b0;
        tx_sh    <= load_byte;
        byte_req <= 1'b1;
      end
    end
  end

  // R3: serial clock is low whenever no byte is in flight
  p_sck_low_idle_r3: assert property (@(posedge clk) disable iff (rst || kill)
    !active |-> !sck);
  // R10: received byte strobe is a single-cycle pulse
  p_rxv_pulse_r10: assert property (@(posedge clk) disable iff (rst || kill)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/spiseq_count.sv
module spiseq_count #(
  parameter int LEN_W  = 10,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [LOOP_W-1:0] loop_m1,
  output logic              last_byte,
  output logic              last_pkt
);
  logic [LEN_W-1:0]  bc;
  logic [LEN_W-1:0]  len_q;
  logic [LOOP_W-1:0] pc;
  logic [LOOP_W-1:0] loop_q;

  assign last_byte = (bc == len_q);
  assign last_pkt  = (pc == loop_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bc     <= '0;
      pc     <= '0;
      len_q  <= '0;
      loop_q <= '0;
    end else if (clr) begin
      bc     <= '0;
      pc     <= '0;
      len_q  <= len_m1;
      loop_q <= loop_m1;
    end else if (step) begin
      if (last_byte) begin
        bc <= '0;
        pc <= last_pkt ? '0 : pc + 1'b1;
      end else begin
        bc <= bc + 1'b1;
      end
    end
  end

  // R4: byte index never passes the latched packet length
  p_byte_bound_r4: assert property (@(posedge clk) disable iff (rst)
    bc <= len_q);
  // R4: packet index never passes the latched packet count
  p_pkt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    pc <= loop_q);

endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
  import spiseq_pkg::*;
#(
  parameter int LEN_W    = 10,
  parameter int LOOP_W   = 8,
  parameter int SCK_HALF = 2,
  parameter int GAP_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_act,
  input  logic              cmd_resume,
  input  logic              cmd_rst,
  input  logic              pause_en,
  input  logic              nonidle_en,
  input  logic              loop_en,
  input  logic              finish_ie,
  input  logic              pause_ie,
  input  logic [LEN_W-1:0]  pkt_len_m1,
  input  logic [LOOP_W-1:0] pkt_loop_m1,
  input  logic [7:0]        tx_byte,
  output logic              byte_req,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              rx_valid,
  output logic [7:0]        rx_byte,
  output logic              busy,
  output logic [1:0]        status,
  output logic              irq
);
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

  seq_state_t  state;
  seq_status_t stat;
  logic [GAP_W-1:0] gcnt;
  logic load, cnt_clr, byte_end, last_byte, last_pkt, hard;

  assign hard   = rst || cmd_rst;
  assign status = stat;

  always_comb begin
    load    = 1'b0;
    cnt_clr = 1'b0;
    unique case (state)
      ST_IDLE:  if (cmd_act)    begin load = 1'b1; cnt_clr = 1'b1; end
      ST_SHIFT: if (byte_end && !last_byte && nonidle_en) load = 1'b1;
      ST_BGAP,
      ST_PGAP:  if (gcnt == '0) load = 1'b1;
      ST_HOLD:  if (cmd_resume) begin load = 1'b1; cnt_clr = 1'b1; end
      default:  ;
    endcase
  end

  spiseq_count #(.LEN_W(LEN_W), .LOOP_W(LOOP_W)) u_count (
    .clk(clk), .rst(hard), .clr(cnt_clr), .step(byte_end),
    .len_m1(pkt_len_m1), .loop_m1(pkt_loop_m1),
    .last_byte(last_byte), .last_pkt(last_pkt)
  );

  spiseq_shift #(.HALF_CYC(SCK_HALF)) u_shift (
    .clk(clk), .rst(rst), .kill(cmd_rst), .load(load), .load_byte(tx_byte),
    .loop_en(loop_en), .miso(miso), .sck(sck), .mosi(mosi),
    .byte_end(byte_end), .byte_req(byte_req),
    .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (hard) begin
      state <= ST_IDLE;
      cs_n  <= 1'b1;
      busy  <= 1'b0;
      stat  <= '0;
      gcnt  <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= (stat.done && finish_ie) || (stat.paused && pause_ie);
      unique case (state)
        ST_IDLE: if (cmd_act) begin
          state <= ST_SHIFT;
          cs_n  <= 1'b0;
          busy  <= 1'b1;
          stat  <= '0;
        end
        ST_SHIFT: if (byte_end) begin
          if (!last_byte) begin
            if (!nonidle_en) begin
              state <= ST_BGAP;
              gcnt  <= GAP_LAST;
            end
          end else if (!last_pkt) begin
            state <= ST_PGAP;
            cs_n  <= 1'b1;
            gcnt  <= GAP_LAST;
          end else if (pause_en) begin
            state       <= ST_HOLD;
            stat.paused <= 1'b1;
          end else begin
            state     <= ST_IDLE;
            cs_n      <= 1'b1;
            busy      <= 1'b0;
            stat.done <= 1'b1;
          end
        end
        ST_BGAP: begin
          if (gcnt == '0) state <= ST_SHIFT;
          else            gcnt  <= gcnt - 1'b1;
        end
        ST_PGAP: begin
          if (gcnt == '0) begin
            state <= ST_SHIFT;
            cs_n  <= 1'b0;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        ST_HOLD: if (cmd_resume) begin
          state <= ST_SHIFT;
          stat  <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: chip select is released whenever no transfer is running
  p_idle_cs_r1: assert property (@(posedge clk) disable iff (hard)
    !busy |-> cs_n);
  // R2: each byte load is acknowledged by exactly one pop cycle
  p_req_single_r2: assert property (@(posedge clk) disable iff (hard)
    byte_req |=> !byte_req);
  // R3: serial clock only toggles inside an asserted chip select
  p_sck_cs_r3: assert property (@(posedge clk) disable iff (hard)
    sck |-> !cs_n);
  // R8: finish and pause are never reported together
  p_stat_excl_r8: assert property (@(posedge clk) disable iff (hard)
    $onehot0(status));
  // R8: paused state keeps chip select asserted
  p_hold_cs_r8: assert property (@(posedge clk) disable iff (hard)
    (state == ST_HOLD) |-> !cs_n);
  // R7: enabled finish status raises the interrupt one cycle later
  p_fin_irq_r7: assert property (@(posedge clk) disable iff (hard)
    (status[0] && finish_ie) |=> irq);

endmodule

// File: tb/spiseq_top_tb_top.sv
`timescale 1ns/1ps
module spiseq_top_tb_top;
  localparam int LEN_W = 10;
  localparam int LOOP_W = 8;
  localparam int H = 2;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_act = 0, cmd_resume = 0, cmd_rst = 0;
  logic pause_en = 0, nonidle_en = 0, loop_en = 0, finish_ie = 0, pause_ie = 0;
  logic [LEN_W-1:0] pkt_len_m1 = '0;
  logic [LOOP_W-1:0] pkt_loop_m1 = '0;
  logic [7:0] tx_byte;
  logic miso = 1'b0;
  logic byte_req, sck, mosi, cs_n, rx_valid, busy, irq;
  logic [7:0] rx_byte;
  logic [1:0] status;

  int n_checks = 0;
  int n_fail = 0;
  int src_idx = 0;
  int rx_cnt = 0;
  int cs_rise = 0;
  logic prev_cs = 1'b1;

  always #4 clk = ~clk;

  function automatic logic [7:0] src_val(input int i);
    return 8'((i * 37 + 5) % 256);
  endfunction
  assign tx_byte = src_val(src_idx);

  spiseq_top #(.LEN_W(LEN_W), .LOOP_W(LOOP_W), .SCK_HALF(H), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst(rst), .cmd_act(cmd_act), .cmd_resume(cmd_resume),
    .cmd_rst(cmd_rst), .pause_en(pause_en), .nonidle_en(nonidle_en),
    .loop_en(loop_en), .finish_ie(finish_ie), .pause_ie(pause_ie),
    .pkt_len_m1(pkt_len_m1), .pkt_loop_m1(pkt_loop_m1), .tx_byte(tx_byte),
    .byte_req(byte_req), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .busy(busy), .status(status),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 shifting, 2 byte gap, 3 packet gap, 4 paused
  int m_state = 0, m_t = 0, m_gap = 0, m_b = 0, m_p = 0, m_lenq = 0, m_loopq = 0;
  bit m_cs = 1, m_busy = 0, m_f = 0, m_pz = 0, m_irq = 0, m_req = 0, m_rv = 0;
  logic [7:0] m_txcur = '0, m_rxb = '0;

  task automatic m_start_byte();
    m_state = 1; m_t = 0; m_txcur = tx_byte; m_req = 1;
  endtask

  always @(posedge clk) begin
    if (rst || cmd_rst) begin
      m_state = 0; m_cs = 1; m_busy = 0; m_f = 0; m_pz = 0; m_irq = 0;
      m_req = 0; m_rv = 0; m_t = 0;
    end else begin
      m_irq = (m_f && finish_ie) || (m_pz && pause_ie);
      m_req = 0; m_rv = 0;
      case (m_state)
        0: if (cmd_act) begin
          m_cs = 0; m_f = 0; m_pz = 0; m_busy = 1; m_b = 0; m_p = 0;
          m_lenq = int'(pkt_len_m1); m_loopq = int'(pkt_loop_m1);
          m_start_byte();
        end
        1: if (m_t == 16 * H - 1) begin
          m_rv = 1;
          m_rxb = loop_en ? m_txcur : {8{miso}};
          if (m_b < m_lenq) begin
            m_b++;
            if (nonidle_en) m_start_byte();
            else begin m_state = 2; m_gap = GAP - 1; end
          end else if (m_p < m_loopq) begin
            m_p++; m_b = 0; m_cs = 1; m_state = 3; m_gap = GAP - 1;
          end else if (pause_en) begin
            m_state = 4; m_pz = 1;
          end else begin
            m_state = 0; m_cs = 1; m_f = 1; m_busy = 0;
          end
        end else m_t++;
        2: if (m_gap == 0) m_start_byte(); else m_gap--;
        3: if (m_gap == 0) begin m_cs = 0; m_start_byte(); end else m_gap--;
        4: if (cmd_resume) begin
          m_f = 0; m_pz = 0; m_b = 0; m_p = 0;
          m_lenq = int'(pkt_len_m1); m_loopq = int'(pkt_loop_m1);
          m_start_byte();
        end
        default: m_state = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      automatic bit e_sck = (m_state == 1) && (((m_t / H) % 2) == 1);
      chk(cs_n == m_cs, "R6 cs_n", cs_n, m_cs);
      chk(busy == m_busy, "R1 busy", busy, m_busy);
      chk(status == {m_pz, m_f}, "R8 status", status, {m_pz, m_f});
      chk(irq == m_irq, "R7 irq", irq, m_irq);
      chk(byte_req == m_req, "R2 byte_req", byte_req, m_req);
      chk(rx_valid == m_rv, "R10 rx_valid", rx_valid, m_rv);
      chk(sck == e_sck, "R3 sck", sck, e_sck);
      if (m_state == 1)
        chk(mosi == m_txcur[7 - m_t / (2 * H)], "R3 mosi", mosi, m_txcur[7 - m_t / (2 * H)]);
      if (m_rv) chk(rx_byte == m_rxb, "R10 rx_byte", rx_byte, m_rxb);
    end
    if (byte_req) src_idx++;
    if (rx_valid) rx_cnt++;
    if (cs_n && !prev_cs) cs_rise++;
    prev_cs = cs_n;
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_act();
    @(negedge clk); cmd_act = 1; @(negedge clk); cmd_act = 0;
  endtask
  task automatic pulse_resume();
    @(negedge clk); cmd_resume = 1; @(negedge clk); cmd_resume = 0;
  endtask
  task automatic wait_state(input int s);
    while (m_state != s) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    ticks(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1 && sck == 0 && busy == 0 && status == 0 && irq == 0,
        "R1 reset outputs", {cs_n, sck, busy, status, irq}, 6'b100000);

    // S1: one packet of 3 bytes, back to back, loopback; start while busy ignored (R2, R5)
    nonidle_en = 1; loop_en = 1; finish_ie = 1; pkt_len_m1 = 2; pkt_loop_m1 = 0;
    rx_cnt = 0;
    pulse_act();
    ticks(10);
    pulse_act();
    wait_state(0);
    chk(rx_cnt == 3, "R4 byte count single packet", rx_cnt, 3);
    chk(status == 2'b01, "R7 finish status", status, 1);
    ticks(2);
    chk(irq == 1, "R7 finish irq", irq, 1);

    // resume while idle is ignored (R8)
    pulse_resume();
    ticks(2);
    chk(busy == 0 && status == 2'b01, "R8 resume ignored in idle", {busy, status}, 3'b001);

    // S2: 3 packets of 2 bytes with gaps, miso high (R5, R6, R10)
    nonidle_en = 0; loop_en = 0; miso = 1; pkt_len_m1 = 1; pkt_loop_m1 = 2;
    rx_cnt = 0; cs_rise = 0;
    pulse_act();
    chk(status == 2'b00, "R7 status cleared by start", status, 0);
    wait_state(0);
    chk(rx_cnt == 6, "R4 byte count three packets", rx_cnt, 6);
    chk(cs_rise == 3, "R6 chip select releases", cs_rise, 3);

    // S3: pause after 2 single-byte packets, then resume (R8)
    miso = 0; loop_en = 1; nonidle_en = 1; pause_en = 1; pause_ie = 1; finish_ie = 0;
    pkt_len_m1 = 0; pkt_loop_m1 = 1;
    pulse_act();
    wait_state(4);
    chk(status == 2'b10, "R8 pause code", status, 2);
    chk(cs_n == 0 && busy == 1, "R8 cs held in pause", {cs_n, busy}, 2'b01);
    ticks(1);
    chk(irq == 1, "R8 pause irq", irq, 1);
    pulse_act();
    ticks(2);
    chk(status == 2'b10, "R2 start ignored while paused", status, 2);
    pause_en = 0;
    pulse_resume();
    wait_state(0);
    ticks(2);
    chk(status == 2'b01 && irq == 0, "R7 finish without enable", {status, irq}, 3'b010);

    // S4: command clear mid transfer (R9), then a single-byte transfer
    pkt_len_m1 = 5; pkt_loop_m1 = 0;
    pulse_act();
    ticks(20);
    @(negedge clk); cmd_rst = 1;
    ticks(2);
    chk(cs_n == 1 && busy == 0 && status == 0 && sck == 0,
        "R9 cleared while held", {cs_n, busy, status, sck}, 5'b10000);
    cmd_rst = 0;
    pkt_len_m1 = 0; pkt_loop_m1 = 0; rx_cnt = 0;
    pulse_act();
    wait_state(0);
    chk(rx_cnt == 1, "R4 single byte transfer", rx_cnt, 1);

    // S5: wide length field and maximum packet count (R4)
    pkt_len_m1 = 10'h100; pkt_loop_m1 = 0; rx_cnt = 0;
    pulse_act();
    wait_state(0);
    chk(rx_cnt == 257, "R4 upper length bit", rx_cnt, 257);
    pkt_len_m1 = 0; pkt_loop_m1 = 8'hFF; rx_cnt = 0; cs_rise = 0;
    pulse_act();
    wait_state(0);
    chk(rx_cnt == 256, "R4 full packet loop", rx_cnt, 256);
    chk(cs_rise == 256, "R6 releases over full loop", cs_rise, 256);

    ticks(4);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule